// File: doc/BRIEF.md
# Byte-Lane Merging Inbound FIFO Writer

This block is the target-side write port of a small inbound word FIFO. A bus front end hands it single-cycle writes made of a strobe, a data word and one enable bit per byte lane. The enabled bytes are merged into a staging word. When a write enables the configured advance lane, the merged word goes into the FIFO and the staging word starts again from zero. Writes that leave the advance lane disabled still store their bytes, so a word can be built from several partial accesses, for example two half-word writes in either order.

The add-on side reads the oldest word from `rd_data` and pops it with `rd_en`. It sees registered full and empty flags. A write that would commit a word while the FIFO is full is refused through `wr_refused`. A refused write changes nothing, so the initiator can retry it. The advance lane comes from a small configuration input, which is normally tied to the top lane (3).

Top module: `lane_merge_fifo_wr`

## Requirements
- R1: After reset `empty` is 1, `full` is 0, and a write that does not enable the advance lane leaves `wr_refused` at 0.
- R2: A write updates exactly the staging bytes whose `wr_be` bit is set. Bit i of `wr_be` covers `wr_data[8*i+7:8*i]`, and other staged bytes keep their values.
- R3: A write with `wr_be` = 4'b1111 while the FIFO is not full commits `wr_data` as one FIFO word in that same access.
- R4: A word can be built from two half-word writes (lanes 0–1 and lanes 2–3) in either order. The commit happens on the half that holds the advance lane. Bytes written earlier are part of that word, and bytes written later go into the next word.
- R5: A write whose `wr_be` bit at index `adv_lane` is 0 never pushes a word, and its enabled bytes are kept for the next commit.
- R6: `adv_lane` picks any lane 0..3 as the advance lane, and the commit condition is `wr_be[adv_lane]`.
- R7: After a commit every staging byte is zero, so lanes that are not written before the next commit read as 0 in that word.
- R8: `wr_refused` is 1 in the same cycle as `wr_en`, `wr_be[adv_lane]` and `full` are all 1. A refused write stores no word and leaves the staging word unchanged.
- R9: Words leave in commit order and the FIFO holds 8 words. `rd_data` shows the oldest word whenever `empty` is 0, and `rd_en` while empty has no effect.
- R10: `full` and `empty` are registered and change at the clock edge that performs the push or pop causing the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_lane | input | 2 | Index of the byte lane whose enable commits the word |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_be | input | 4 | Byte-lane enables of the write |
| wr_data | input | 32 | Write data |
| wr_refused | output | 1 | Committing write rejected because the FIFO is full |
| rd_en | input | 1 | Pop the oldest word |
| rd_data | output | 32 | Oldest word (show-ahead) |
| full | output | 1 | FIFO holds 8 words |
| empty | output | 1 | FIFO holds no word |

## Verification
`wr_refused` depends only on the inputs of the current access and the present `full` state. It is therefore checked in the same cycle, shortly after the inputs settle and before the clock edge. A committed word, the staging effect of a partial write, a pop and both flags all take effect at the next rising edge. Because reads are show-ahead, a word pushed into an empty FIFO appears on `rd_data` right after the edge that stores it. The bench drives each access on the falling edge, updates its reference model at the rising edge, and compares flags and the head word on the following falling edge, so every result is sampled exactly one edge after the stimulus that causes it.

// File: rtl/lmf_pkg.sv
package lmf_pkg;

   localparam int unsigned LMF_BYTE_W = 8;

   typedef enum logic [1:0] {
      LMF_ACT_IDLE = 2'b00,
      LMF_ACT_PUSH = 2'b01,
      LMF_ACT_POP  = 2'b10,
      LMF_ACT_BOTH = 2'b11
   } lmf_act_e;

   function automatic lmf_act_e lmf_action(input logic push, input logic pop);
      return lmf_act_e'({pop, push});
   endfunction

endpackage

// File: rtl/lmf_stage.sv
module lmf_stage #(
   parameter int unsigned LANES  = 4,
   parameter int unsigned BYTE_W = lmf_pkg::LMF_BYTE_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clear_i,
   input  logic [LANES-1:0]          lane_we_i,
   input  logic [LANES-1:0]          merge_be_i,
   input  logic [LANES*BYTE_W-1:0]   data_i,
   output logic [LANES*BYTE_W-1:0]   stage_o,
   output logic [LANES*BYTE_W-1:0]   merged_o
);

   localparam int unsigned WORD_W = LANES * BYTE_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("lmf_stage: LANES must be at least 1");
   end

   logic [WORD_W-1:0] stage_q;

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n || clear_i) begin
            stage_q[ln*BYTE_W +: BYTE_W] <= '0;
         end else if (lane_we_i[ln]) begin
            stage_q[ln*BYTE_W +: BYTE_W] <= data_i[ln*BYTE_W +: BYTE_W];
         end
      end

      assign merged_o[ln*BYTE_W +: BYTE_W] = merge_be_i[ln] ?
                                             data_i[ln*BYTE_W +: BYTE_W] :
                                             stage_q[ln*BYTE_W +: BYTE_W];
   end

   assign stage_o = stage_q;

   // R7: a clear leaves every staged byte at zero
   assert_stage_cleared_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (stage_q == '0));

   // R2: lanes without a write enable hold their byte
   assert_lane_hold_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && !lane_we_i[0]) |=> $stable(stage_q[BYTE_W-1:0]));

endmodule

// File: rtl/lmf_fifo.sv
module lmf_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] push_data_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] head_o,
   output logic             full_o,
   output logic             empty_o
);
   import lmf_pkg::*;

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("lmf_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("lmf_fifo: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             full_q, empty_q;
   logic             push_acc, pop_acc;
   lmf_act_e         act;

   assign push_acc = push_i && !full_q;
   assign pop_acc  = pop_i && !empty_q;
   assign act      = lmf_action(push_acc, pop_acc);

   function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
      return (p == PTR_LAST) ? '0 : p + 1'b1;
   endfunction

   always_comb begin
      unique case (act)
         LMF_ACT_PUSH: cnt_d = cnt_q + 1'b1;
         LMF_ACT_POP:  cnt_d = cnt_q - 1'b1;
         default:      cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (push_acc) begin
         mem[wr_ptr_q] <= push_data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
         full_q   <= 1'b0;
         empty_q  <= 1'b1;
      end else begin
         if (push_acc) wr_ptr_q <= ptr_inc(wr_ptr_q);
         if (pop_acc)  rd_ptr_q <= ptr_inc(rd_ptr_q);
         cnt_q   <= cnt_d;
         full_q  <= (cnt_d == CNT_MAX);
         empty_q <= (cnt_d == '0);
      end
   end

   assign head_o  = mem[rd_ptr_q];
   assign full_o  = full_q;
   assign empty_o = empty_q;

   // R10: full only rises on the edge of a push
   assert_full_rise_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full_q) |-> $past(push_i));

   // R10: empty only falls on the edge of a push
   assert_empty_fall_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(empty_q) |-> $past(push_i));

   // R9: the flags never claim full and empty together
   assert_flags_exclusive_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !(full_q && empty_q));

   // R9: a pop with no push from a non-empty FIFO leaves room
   assert_pop_frees_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && !empty_q) |=> !full_q);

   // R9: occupancy stays within the depth
   assert_no_overflow_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);

endmodule

// File: rtl/lane_merge_fifo_wr.sv
module lane_merge_fifo_wr #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned FIFO_DEPTH = 8
) (
   input  logic                                           clk,
   input  logic                                           rst_n,
   input  logic [$clog2(DATA_W/lmf_pkg::LMF_BYTE_W)-1:0]  adv_lane,
   input  logic                                           wr_en,
   input  logic [DATA_W/lmf_pkg::LMF_BYTE_W-1:0]          wr_be,
   input  logic [DATA_W-1:0]                              wr_data,
   output logic                                           wr_refused,
   input  logic                                           rd_en,
   output logic [DATA_W-1:0]                              rd_data,
   output logic                                           full,
   output logic                                           empty
);
   import lmf_pkg::*;

   localparam int unsigned LANES = DATA_W / LMF_BYTE_W;

   if ((DATA_W % LMF_BYTE_W) != 0) begin : g_bad_width
      $error("lane_merge_fifo_wr: DATA_W must be a whole number of bytes");
   end
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("lane_merge_fifo_wr: lane count must be a power of two, at least 2");
   end

   logic              adv_hit;
   logic              commit_req;
   logic              commit_acc;
   logic [LANES-1:0]  stage_we;
   logic [DATA_W-1:0] stage_word;
   logic [DATA_W-1:0] merged_word;

   assign adv_hit    = wr_be[adv_lane];
   assign commit_req = wr_en && adv_hit;
   assign commit_acc = commit_req && !full;
   assign wr_refused = commit_req && full;
   assign stage_we   = (wr_en && !adv_hit) ? wr_be : '0;

   lmf_stage #(
      .LANES  (LANES),
      .BYTE_W (LMF_BYTE_W)
   ) stage_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (commit_acc),
      .lane_we_i  (stage_we),
      .merge_be_i (wr_be),
      .data_i     (wr_data),
      .stage_o    (stage_word),
      .merged_o   (merged_word)
   );

   lmf_fifo #(
      .WIDTH (DATA_W),
      .DEPTH (FIFO_DEPTH)
   ) fifo_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (commit_req),
      .push_data_i (merged_word),
      .pop_i       (rd_en),
      .head_o      (rd_data),
      .full_o      (full),
      .empty_o     (empty)
   );

   // R8: a refused write leaves the staging word untouched
   assert_refused_holds_stage_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_refused |=> $stable(stage_word));

   // R3: a full-width write into a non-full FIFO leaves it non-empty
   assert_full_word_commits_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (&wr_be) && !full) |=> !empty);

   // R5: a write without the advance lane pushes nothing
   assert_no_advance_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_be[adv_lane] && !rd_en) |=> $stable(empty) && $stable(full));

   // R1: nothing is refused unless the FIFO is full
   assert_refuse_needs_full_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_refused |-> full);

endmodule

// File: tb/lane_merge_fifo_wr_tb_top.sv
`timescale 1ns/1ps
module lane_merge_fifo_wr_tb_top;

   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  adv_lane = 2'd3;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_be = 4'h0;
   logic [31:0] wr_data = '0;
   logic        wr_refused;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        full, empty;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] m_stage = '0;
   logic [31:0] m_q[$];

   always #2.5 clk = ~clk;

   lane_merge_fifo_wr dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv_lane   (adv_lane),
      .wr_en      (wr_en),
      .wr_be      (wr_be),
      .wr_data    (wr_data),
      .wr_refused (wr_refused),
      .rd_en      (rd_en),
      .rd_data    (rd_data),
      .full       (full),
      .empty      (empty)
   );

   function automatic logic [31:0] merge_fn(input logic [31:0] s, input logic [31:0] d,
                                            input logic [3:0] be);
      logic [31:0] r = s;
      for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = d[i*8 +: 8];
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_outputs(input string req);
      chk(empty == (m_q.size() == 0), "R10", {req, " empty flag"}, 32'(empty), 32'(m_q.size() == 0));
      chk(full == (m_q.size() == DEPTH), "R10", {req, " full flag"}, 32'(full), 32'(m_q.size() == DEPTH));
      if (m_q.size() != 0)
         chk(rd_data == m_q[0], "R9", {req, " head word"}, rd_data, m_q[0]);
   endtask

   // One access: drive at the falling edge, check wr_refused before the
   // rising edge, update the model at the edge, check state one edge later.
   task automatic step(input bit w, input logic [3:0] be, input logic [31:0] d,
                       input bit r, input string req);
      bit hit, is_full, refuse;
      logic [31:0] mrg;
      wr_en = w; wr_be = be; wr_data = d; rd_en = r;
      hit     = w && be[adv_lane];
      is_full = (m_q.size() == DEPTH);
      refuse  = hit && is_full;
      #1;
      chk(wr_refused == refuse, "R8", {req, " wr_refused"}, 32'(wr_refused), 32'(refuse));
      @(posedge clk);
      mrg = merge_fn(m_stage, d, be);
      if (r && m_q.size() != 0) void'(m_q.pop_front());
      if (w) begin
         if (hit && !is_full) begin
            m_q.push_back(mrg);
            m_stage = '0;
         end else if (!hit) begin
            m_stage = mrg;
         end
      end
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check_outputs(req);
   endtask

   task automatic drain(input string req);
      while (m_q.size() != 0) step(1'b0, 4'h0, '0, 1'b1, req);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(empty == 1'b1, "R1", "empty after reset", 32'(empty), 32'd1);
      chk(full == 1'b0, "R1", "full after reset", 32'(full), 32'd0);
      step(1'b1, 4'b0001, 32'h0000_00aa, 1'b0, "R1");
      chk(empty == 1'b1, "R1", "no push from partial", 32'(empty), 32'd1);

      // R3: full-width writes commit in one access
      step(1'b1, 4'b1110, 32'h1122_3300, 1'b0, "R3");
      chk(rd_data == 32'h1122_33aa, "R2", "partial lanes merged", rd_data, 32'h1122_33aa);
      step(1'b1, 4'b1111, 32'hdead_beef, 1'b0, "R3");
      drain("R9");

      // R4: half-word pair low then high, advance lane 3
      step(1'b1, 4'b0011, 32'h0000_5678, 1'b0, "R4");
      step(1'b1, 4'b1100, 32'h1234_0000, 1'b0, "R4");
      chk(rd_data == 32'h1234_5678, "R4", "low-high pair", rd_data, 32'h1234_5678);
      drain("R4");

      // R4/R6: high then low with advance lane 0
      adv_lane = 2'd0;
      step(1'b1, 4'b1100, 32'hcafe_0000, 1'b0, "R6");
      chk(empty == 1'b1, "R5", "high half held", 32'(empty), 32'd1);
      step(1'b1, 4'b0011, 32'h0000_f00d, 1'b0, "R6");
      chk(rd_data == 32'hcafe_f00d, "R4", "high-low pair lane0", rd_data, 32'hcafe_f00d);
      drain("R6");

      // R7: high then low with advance lane 3 commits high half alone
      adv_lane = 2'd3;
      step(1'b1, 4'b1100, 32'habcd_0000, 1'b0, "R7");
      chk(rd_data == 32'habcd_0000, "R7", "unwritten lanes zero", rd_data, 32'habcd_0000);
      step(1'b1, 4'b0011, 32'h0000_0101, 1'b0, "R7");
      step(1'b1, 4'b1000, 32'h7700_0000, 1'b0, "R7");
      drain("R7");

      // R8: fill, stage a byte, refused write, then commit after a pop
      for (int i = 0; i < DEPTH; i++) step(1'b1, 4'hf, 32'h1000_0000 + i, 1'b0, "R9");
      chk(full == 1'b1, "R9", "full after 8 words", 32'(full), 32'd1);
      step(1'b1, 4'b0001, 32'h0000_0055, 1'b0, "R8");
      step(1'b1, 4'b1100, 32'h9999_0000, 1'b0, "R8");
      step(1'b0, 4'h0, '0, 1'b1, "R8");
      step(1'b1, 4'b1000, 32'h4400_0000, 1'b0, "R8");
      drain("R8");
      chk(m_stage == 32'h0 && empty, "R8", "refused write left no trace", 32'(empty), 32'd1);
      step(1'b0, 4'h0, '0, 1'b1, "R9");

      // Random mix, reference model checks every popped word
      for (int it = 0; it < 4000; it++) begin
         int pop_pct = ((it / 500) % 2 == 0) ? 25 : 70;
         int kind = $urandom_range(0, 4);
         bit r0 = ($urandom_range(0, 99) < pop_pct);
         bit r1 = ($urandom_range(0, 99) < pop_pct);
         if (it % 200 == 0) adv_lane = 2'($urandom_range(0, 3));
         case (kind)
            0: step(1'b1, 4'hf, $urandom, r0, "R3");
            1: begin
                  step(1'b1, 4'b0011, $urandom, r0, "R4");
                  step(1'b1, 4'b1100, $urandom, r1, "R4");
               end
            2: begin
                  step(1'b1, 4'b1100, $urandom, r0, "R4");
                  step(1'b1, 4'b0011, $urandom, r1, "R4");
               end
            3: step(1'b1, 4'($urandom_range(0, 15)), $urandom, r0, "R2");
            default: step(1'b0, 4'h0, '0, 1'b1, "R9");
         endcase
      end
      adv_lane = 2'd3;
      drain("R9");
      step(1'b0, 4'h0, '0, 1'b1, "R9");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule